// File: doc/BRIEF.md
# Burst Address Counter with Readback

This block generates the word address that one port of a synchronous memory uses on every access. On each rising clock edge it picks one of five actions from three active-low controls: clear the counter, load an external address, advance by one, freeze, or freeze while the counter value is shown on the data output in place of memory data. The counter covers the whole array and wraps from the last word to zero.

The address it drives is the value after the current edge's update. A load or clear therefore takes effect for the access in that same cycle, with no dead cycle. The memory array, the output pipeline and the sub-word lane selection of narrow ports live outside this block. Chip enable plays no part in the counter.

Top module: `burst_addr_ctr`

## Requirements
- R1: When `clr_n` is low at a rising edge, the access address becomes 0 after that edge, whatever `strobe_n` and `step_n` are. Clearing costs no extra cycle, so the access in that cycle uses address 0.
- R2: When `clr_n` is high and both `strobe_n` and `step_n` are low, `ext_addr` is loaded, and `acc_addr` equals it right after that edge.
- R3: When `clr_n` is high, `strobe_n` is high and `step_n` is low, `acc_addr` increases by one at each edge.
- R4: When `clr_n`, `strobe_n` and `step_n` are all high, `acc_addr` keeps its value and changes to `ext_addr` have no effect.
- R5: When `clr_n` is high, `strobe_n` is low and `step_n` is high, the counter keeps its value. If `rd_cyc` is also high, then for the following cycle `dout` carries the counter value in bits `[RB_LSB +: AW]` (bits 3 to 17 by default), with every other bit zero.
- R6: Advancing from address `DEPTH-1` gives 0.
- R7: In every cycle that does not follow a readback edge (R5 with `rd_cyc` high), `dout` equals `mem_rdata`.
- R8: While `rst_n` is low, `acc_addr` is 0 and `dout` passes `mem_rdata` through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_addr | input | AW | External word address |
| strobe_n | input | 1 | Address strobe, active low |
| step_n | input | 1 | Count enable, active low |
| clr_n | input | 1 | Counter clear, active low, highest priority |
| rd_cyc | input | 1 | High when this cycle is a read |
| mem_rdata | input | DW | Read data from the memory array |
| acc_addr | output | AW | Address used by the current access |
| dout | output | DW | Memory data, or the counter value during readback |

## Verification
The assertions take the control inputs to be stable and known at each sampled rising edge, and `mem_rdata` to be a plain data input with no dependence on `acc_addr`. The stimulus drives every input on the falling edge and holds it for a full cycle. It also supplies memory data from the bench rather than from a model array, so the passthrough and readback checks see only the value the driver chose.

// File: rtl/bac_pkg.sv
package bac_pkg;

   // Action taken by the counter at the next rising edge.
   typedef enum logic [2:0] {
      BAC_CLEAR  = 3'd0,
      BAC_LOAD   = 3'd1,
      BAC_PEEK   = 3'd2,
      BAC_FREEZE = 3'd3,
      BAC_STEP   = 3'd4
   } bac_mode_e;

endpackage

// File: rtl/bac_mode_decode.sv
module bac_mode_decode
   import bac_pkg::*;
(
   input  logic      clr_n,
   input  logic      strobe_n,
   input  logic      step_n,
   output bac_mode_e mode
);

   // Clear wins over everything; the other four follow from strobe/step.
   always_comb begin
      if (!clr_n) begin
         mode = BAC_CLEAR;
      end else begin
         unique case ({strobe_n, step_n})
            2'b00:   mode = BAC_LOAD;
            2'b01:   mode = BAC_PEEK;
            2'b10:   mode = BAC_STEP;
            default: mode = BAC_FREEZE;
         endcase
      end
   end

endmodule

// File: rtl/bac_counter.sv
module bac_counter
   import bac_pkg::*;
#(
   parameter int AW    = 15,
   parameter int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bac_mode_e     mode,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] cnt_q
);

   localparam logic [AW-1:0] LAST_WORD = AW'(DEPTH - 1);
   localparam bit            FULL_SPAN = (DEPTH == (1 << AW));

   logic [AW-1:0] cnt_inc;
   logic [AW-1:0] cnt_d;

   generate
      if (FULL_SPAN) begin : g_natural_wrap
         // A power-of-two array wraps by plain overflow.
         assign cnt_inc = cnt_q + AW'(1);
      end else begin : g_compare_wrap
         // A partial array needs an explicit end-of-array compare.
         assign cnt_inc = (cnt_q == LAST_WORD) ? '0 : cnt_q + AW'(1);
      end
   endgenerate

   always_comb begin
      unique case (mode)
         BAC_CLEAR: cnt_d = '0;
         BAC_LOAD:  cnt_d = addr_in;
         BAC_STEP:  cnt_d = cnt_inc;
         default:   cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BAC_CLEAR) |=> (cnt_q == '0))
      else $error("R1: counter not zero after clear");

   p_load_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BAC_LOAD) |=> (cnt_q == $past(addr_in)))
      else $error("R2: external address not loaded");

   p_step_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BAC_STEP && cnt_q != LAST_WORD) |=> (cnt_q == $past(cnt_q) + AW'(1)))
      else $error("R3: counter did not advance by one");

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BAC_FREEZE || mode == BAC_PEEK) |=> $stable(cnt_q))
      else $error("R4: counter moved while held");

   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BAC_STEP && cnt_q == LAST_WORD) |=> (cnt_q == '0))
      else $error("R6: counter did not wrap to zero");

endmodule

// File: rtl/bac_readback.sv
module bac_readback
   import bac_pkg::*;
#(
   parameter int AW     = 15,
   parameter int DW     = 36,
   parameter int RB_LSB = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bac_mode_e     mode,
   input  logic          rd_cyc,
   input  logic [AW-1:0] cnt_q,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] dout
);

   localparam int RB_MSB = RB_LSB + AW - 1;

   logic          show_q;
   logic [DW-1:0] rb_word;

   // Readback is chosen at the edge and applies to the whole next cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) show_q <= 1'b0;
      else        show_q <= (mode == BAC_PEEK) && rd_cyc;
   end

   generate
      if (RB_LSB == 0 && RB_MSB == DW - 1) begin : g_full_field
         assign rb_word = cnt_q;
      end else begin : g_zero_fill
         always_comb begin
            rb_word                 = '0;
            rb_word[RB_LSB +: AW]   = cnt_q;
         end
      end
   endgenerate

   assign dout = show_q ? rb_word : mem_rdata;

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
   import bac_pkg::*;
#(
   parameter int AW     = 15,
   parameter int DW     = 36,
   parameter int RB_LSB = 3,
   parameter int DEPTH  = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ext_addr,
   input  logic          strobe_n,
   input  logic          step_n,
   input  logic          clr_n,
   input  logic          rd_cyc,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] acc_addr,
   output logic [DW-1:0] dout
);

   generate
      if (AW < 14 || AW > 15) begin : g_bad_aw
         $error("burst_addr_ctr: AW must be 14 or 15");
      end
      if (RB_LSB + AW > DW) begin : g_bad_field
         $error("burst_addr_ctr: readback field exceeds data width");
      end
      if (DEPTH < 2 || DEPTH > (1 << AW)) begin : g_bad_depth
         $error("burst_addr_ctr: DEPTH out of range for AW");
      end
   endgenerate

   bac_mode_e     mode;
   logic [AW-1:0] cnt_q;

   bac_mode_decode u_decode (
      .clr_n    (clr_n),
      .strobe_n (strobe_n),
      .step_n   (step_n),
      .mode     (mode)
   );

   bac_counter #(
      .AW    (AW),
      .DEPTH (DEPTH)
   ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .addr_in (ext_addr),
      .cnt_q   (cnt_q)
   );

   bac_readback #(
      .AW     (AW),
      .DW     (DW),
      .RB_LSB (RB_LSB)
   ) u_readback (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .rd_cyc    (rd_cyc),
      .cnt_q     (cnt_q),
      .mem_rdata (mem_rdata),
      .dout      (dout)
   );

   assign acc_addr = cnt_q;

   p_clear_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> (acc_addr == '0))
      else $error("R1: clear did not override other controls");

   p_peek_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !strobe_n && step_n && rd_cyc)
         |=> (dout[RB_LSB +: AW] == acc_addr && acc_addr == $past(acc_addr)))
      else $error("R5: readback field wrong");

   p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_n && !strobe_n && step_n && rd_cyc) |=> (dout == mem_rdata))
      else $error("R7: memory data not passed through");

   always_comb begin
      if (!rst_n) begin
         a_reset_r8: assert (acc_addr == '0 || $isunknown(acc_addr))
            else $error("R8: address not zero in reset");
      end
   end

endmodule

// File: tb/burst_addr_ctr_tb.sv
`timescale 1ns/1ps
module burst_addr_ctr_tb;

   localparam int AW = 15;
   localparam int DW = 36;
   localparam int RB = 3;
   localparam int DEPTH = 1 << AW;

   typedef struct {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic          strobe_n = 1'b1;
   logic          step_n = 1'b1;
   logic          clr_n = 1'b1;
   logic          rd_cyc = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic [AW-1:0] acc_addr;
   logic [DW-1:0] dout;

   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;
   exp_t exp_q[$];

   int m_cnt = 0;

   always #2.5 clk = ~clk;

   burst_addr_ctr #(.AW(AW), .DW(DW), .RB_LSB(RB), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strobe_n(strobe_n),
      .step_n(step_n), .clr_n(clr_n), .rd_cyc(rd_cyc), .mem_rdata(mem_rdata),
      .acc_addr(acc_addr), .dout(dout)
   );

   // Driver: applies one cycle of controls at the falling edge and queues
   // the outcome expected just after the following rising edge.
   task automatic drive(input bit clr, input bit strb, input bit stp,
                        input bit rd, input int addr,
                        input logic [DW-1:0] mem, input string tag);
      exp_t e;
      bit   show;
      @(negedge clk);
      clr_n = clr; strobe_n = strb; step_n = stp; rd_cyc = rd;
      ext_addr = AW'(addr); mem_rdata = mem;
      show = 1'b0;
      if (!clr)              m_cnt = 0;
      else if (!strb && !stp) m_cnt = addr;
      else if (strb && !stp)  m_cnt = (m_cnt + 1) % DEPTH;
      else if (!strb && stp)  show = rd;
      e.a   = AW'(m_cnt);
      e.d   = show ? (DW'(m_cnt) << RB) : mem;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: compares one queued item per edge, 1 ns after the edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_run++;
            if (acc_addr !== e.a || dout !== e.d) begin
               n_fail++;
               $display("FAIL %s: addr=%h dout=%h expected addr=%h dout=%h",
                        e.tag, acc_addr, dout, e.a, e.d);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
   end

   initial begin
      mem_rdata = 36'hA_5A5A_5A5A;
      repeat (3) @(negedge clk);
      n_run++;
      if (acc_addr !== '0 || dout !== mem_rdata) begin
         n_fail++;
         $display("FAIL R8: addr=%h dout=%h expected addr=0 dout=%h",
                  acc_addr, dout, mem_rdata);
      end
      @(negedge clk); rst_n = 1'b1;

      // R2: load, visible in the same access
      drive(1, 0, 0, 0, 'h1234, 36'h1_1111_1111, "R2");
      // R3: advance
      drive(1, 1, 0, 0, 'h0,    36'h2_2222_2222, "R3");
      drive(1, 1, 0, 1, 'h7F00, 36'h3_3333_3333, "R3");
      drive(1, 1, 0, 0, 'h0,    36'h4_4444_4444, "R3");
      // R4: hold, external address ignored
      drive(1, 1, 1, 0, 'h0AAA, 36'h5_5555_5555, "R4");
      drive(1, 1, 1, 1, 'h7555, 36'h6_6666_6666, "R4");
      // R5: readback during a read, then a held cycle without read
      drive(1, 0, 1, 1, 'h0001, 36'h7_7777_7777, "R5");
      drive(1, 0, 1, 1, 'h0002, 36'h8_8888_8888, "R5");
      drive(1, 0, 1, 0, 'h0003, 36'h9_9999_9999, "R7");
      // R7: load during a read passes memory data
      drive(1, 0, 0, 1, 'h4321, 36'hF_0F0F_0F0F, "R7");
      // R1: clear overrides a load request and a step request
      drive(0, 0, 0, 1, 'h7777, 36'hC_CCCC_CCCC, "R1");
      drive(1, 1, 0, 0, 'h0,    36'h0_0000_0001, "R3");
      drive(0, 1, 0, 0, 'h0,    36'h0_0000_0002, "R1");
      drive(0, 0, 1, 1, 'h0,    36'h0_0000_0003, "R1");
      // R6: wrap from the last word
      drive(1, 0, 0, 0, DEPTH - 2, 36'hE_EEEE_EEEE, "R2");
      drive(1, 1, 0, 0, 'h0,       36'hD_DDDD_DDDD, "R6");
      drive(1, 1, 0, 0, 'h0,       36'hB_BBBB_BBBB, "R6");
      drive(1, 1, 0, 0, 'h0,       36'h0_1234_5678, "R6");
      // R5: readback of the highest address shows every field bit
      drive(1, 0, 0, 0, DEPTH - 1, 36'h0,           "R2");
      drive(1, 0, 1, 1, 'h0,       36'hF_FFFF_FFFF, "R5");
      drive(1, 1, 1, 0, 'h0,       36'hF_FFFF_FFFF, "R7");

      @(negedge clk);
      clr_n = 1'b1; strobe_n = 1'b1; step_n = 1'b1; rd_cyc = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule